// File: doc/BRIEF.md
# Linked Channel Pair Interrupt Subnode

This block sits beside an event-driven transfer engine whose channels are grouped in pairs for chained block transfers. For every pair it watches the transfer counters and the per-channel link flags of the channel currently in use. When a linked block is about to run out (its count falls from one to zero on a transfer strobe), it raises a pending request for that pair. Software can then reload the control registers for the next block while the other channel of the pair carries the transfer forward.

All pairs share one interrupt line, and each pair has its own enable. A 16-bit subnode register holds one enable bit and one request bit per pair. Each pair also runs a small state machine with three states: LNK_OFF (link mode idle, channel A in use), LNK_CHA (linked, channel A active) and LNK_CHB (linked, channel B active, toggle set). The transitions are:

- ENTER: LNK_OFF to LNK_CHA, on a strobe with the A link flag set.
- SWAP_AB: LNK_CHA or LNK_OFF to LNK_CHB, on block completion while at least one link flag of the pair is set.
- SWAP_BA: LNK_CHB to LNK_CHA, on block completion while at least one link flag is set.
- UNLINK: any state to LNK_OFF, on block completion while both link flags are clear.

A service request that reaches a channel whose count is already zero and whose link flag is clear produces that channel's ordinary interrupt pulse instead.

Top module: `chlink_irq_subnode`

## Requirements
- R1: Pair index k (pair numbers 0, 2, 4, 6 for k = 0..3) has its enable bit at register bit 4k and its request bit at bit 4k+1. All other bits read 0, so writing 0xFFFF reads back as 0x3333.
- R2: After reset the register reads 0x0000, the combined interrupt is low, every toggle is low and no standard interrupt is pulsed.
- R3: In single-transfer mode (pkg low), a strobe on which the active channel's count goes from 1, as sampled on the previous strobe, to 0 while that channel's link flag is set sets the pair's request bit on that clock edge.
- R4: In package-transfer mode (pkg high), the secondary count is compared instead, and a 1-to-0 change of the primary count alone sets nothing.
- R5: A block completion while the active channel's link flag is clear does not set the pair's request bit.
- R6: The combined interrupt output is high exactly while some pair has both its request bit and its enable bit set.
- R7: A service request while the active channel's count is 0 and its link flag is clear pulses that channel's standard interrupt (output bit 2k for A, 2k+1 for B) for one cycle on the next cycle. It sets no request bit.
- R8: At each block completion while either link flag of the pair is set, the pair's toggle flips (A to B or B to A).
- R9: At a block completion with both link flags of the pair clear, link mode ends and the toggle is cleared.
- R10: A register write stores each enable and request bit from the write data, so writing 0 clears a request. A hardware set in the same cycle as a clearing write leaves the request bit at 1.
- R11: Counter changes without a strobe do nothing. Detection uses only values sampled on strobes, and the first strobe after a completion only samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read value |
| stb_i | input | 4 | Per-pair transfer strobe |
| pkg_i | input | 4 | Per-pair package-transfer mode select |
| req_i | input | 4 | Per-pair service request hitting the active channel |
| cnt_i | input | 4x2x8 | Primary count per pair and channel (index 0 = A, 1 = B) |
| cnt2_i | input | 4x2x4 | Secondary (package) count per pair and channel |
| link_i | input | 4x2 | Link flag per pair and channel |
| toggle_o | output | 4 | Per-pair toggle (1 = channel B active) |
| std_irq_o | output | 8 | Standard interrupt pulse per channel |
| irq_o | output | 1 | Combined channel-link interrupt |

## Verification
The assertions take for granted that the counter, mode and link inputs are steady across a clock edge, and that a strobe always describes the channel the block currently regards as active. They also take for granted that a software write and a hardware set may collide on the same edge. The stimulus changes every input only on the falling edge and steers each strobe to the channel given by the observed toggle. It deliberately lines up one clearing write with a counter drop so that the collision rule is exercised.

// File: rtl/chlink_pkg.sv
package chlink_pkg;
    typedef enum logic [1:0] {
        LNK_OFF = 2'd0,
        LNK_CHA = 2'd1,
        LNK_CHB = 2'd2
    } lnk_state_e;

    localparam int BITS_PER_PAIR = 4;
    localparam int IE_OFS = 0;
    localparam int IR_OFS = 1;
endpackage

// File: rtl/chlink_pair.sv
module chlink_pair
    import chlink_pkg::*;
#(
    parameter int CW  = 8,
    parameter int C2W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb_i,
    input  logic                 pkg_i,
    input  logic                 req_i,
    input  logic [1:0][CW-1:0]   cnt_i,
    input  logic [1:0][C2W-1:0]  cnt2_i,
    input  logic [1:0]           link_i,
    output logic                 hw_set_o,
    output logic                 toggle_o,
    output logic [1:0]           std_o
);
    lnk_state_e     state_q, state_d;
    logic [CW-1:0]  prev_cnt_q;
    logic [C2W-1:0] prev_cnt2_q;
    logic           prev_vld_q;
    logic [1:0]     std_q;

    logic           act;
    logic [CW-1:0]  cur_cnt;
    logic [C2W-1:0] cur_cnt2;
    logic           cur_link;
    logic           any_link;
    logic           cnt_drop;
    logic           blk_done;

    assign act      = (state_q == LNK_CHB);
    assign cur_cnt  = cnt_i[act];
    assign cur_cnt2 = cnt2_i[act];
    assign cur_link = link_i[act];
    assign any_link = |link_i;
    assign cnt_drop = pkg_i ? ((prev_cnt2_q == C2W'(1)) && (cur_cnt2 == '0))
                            : ((prev_cnt_q == CW'(1)) && (cur_cnt == '0));
    assign blk_done = stb_i & prev_vld_q & cnt_drop;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_OFF: begin
                if (blk_done)                state_d = any_link ? LNK_CHB : LNK_OFF;
                else if (stb_i && cur_link)  state_d = LNK_CHA;
            end
            LNK_CHA: if (blk_done) state_d = any_link ? LNK_CHB : LNK_OFF;
            LNK_CHB: if (blk_done) state_d = any_link ? LNK_CHA : LNK_OFF;
            default: state_d = LNK_OFF;
        endcase
    end

    // state and sampled counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= LNK_OFF;
            prev_cnt_q  <= '0;
            prev_cnt2_q <= '0;
            prev_vld_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (stb_i) begin
                if (blk_done) begin
                    prev_vld_q <= 1'b0;
                end else begin
                    prev_cnt_q  <= cur_cnt;
                    prev_cnt2_q <= cur_cnt2;
                    prev_vld_q  <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            std_q <= '0;
        end else begin
            std_q <= '0;
            if (req_i && (cur_cnt == '0) && !cur_link) std_q[act] <= 1'b1;
        end
    end

    assign hw_set_o = blk_done & cur_link;
    assign toggle_o = (state_q == LNK_CHB);
    assign std_o    = std_q;

    // R9
    unlink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && prev_vld_q && cnt_drop && !any_link) |=> (state_q == LNK_OFF && !toggle_o));
    // R8
    swap_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && any_link && !toggle_o) |=> toggle_o);
    // R11
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(state_q) && $stable(prev_vld_q)));
    // R7
    std_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|std_o) |-> ($past(req_i) && $onehot0(std_o)));
endmodule

// File: rtl/chlink_regs.sv
module chlink_regs
    import chlink_pkg::*;
#(
    parameter int NPAIR = 4,
    localparam int RW   = NPAIR * BITS_PER_PAIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [RW-1:0]    wdata_i,
    input  logic [NPAIR-1:0] hw_set_i,
    output logic [RW-1:0]    rdata_o,
    output logic             irq_o
);
    logic [NPAIR-1:0] ie_q;
    logic [NPAIR-1:0] ir_q;

    for (genvar p = 0; p < NPAIR; p++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ie_q[p] <= 1'b0;
                ir_q[p] <= 1'b0;
            end else begin
                if (wr_en_i) ie_q[p] <= wdata_i[p*BITS_PER_PAIR + IE_OFS];
                if (hw_set_i[p])  ir_q[p] <= 1'b1;
                else if (wr_en_i) ir_q[p] <= wdata_i[p*BITS_PER_PAIR + IR_OFS];
            end
        end

        // R10
        hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set_i[p] |=> rdata_o[p*BITS_PER_PAIR + IR_OFS]);
    end

    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NPAIR; p++) begin
            rdata_o[p*BITS_PER_PAIR + IE_OFS] = ie_q[p];
            rdata_o[p*BITS_PER_PAIR + IR_OFS] = ir_q[p];
        end
    end

    assign irq_o = |(ie_q & ir_q);

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($countones(ir_q & ie_q) > 0));
endmodule

// File: rtl/chlink_irq_subnode.sv
module chlink_irq_subnode
    import chlink_pkg::*;
#(
    parameter int NPAIR = 4,
    parameter int CW    = 8,
    parameter int C2W   = 4,
    localparam int RW   = NPAIR * BITS_PER_PAIR
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [RW-1:0]                wdata_i,
    output logic [RW-1:0]                rdata_o,
    input  logic [NPAIR-1:0]             stb_i,
    input  logic [NPAIR-1:0]             pkg_i,
    input  logic [NPAIR-1:0]             req_i,
    input  logic [NPAIR-1:0][1:0][CW-1:0]  cnt_i,
    input  logic [NPAIR-1:0][1:0][C2W-1:0] cnt2_i,
    input  logic [NPAIR-1:0][1:0]        link_i,
    output logic [NPAIR-1:0]             toggle_o,
    output logic [2*NPAIR-1:0]           std_irq_o,
    output logic                         irq_o
);
    logic [NPAIR-1:0] hw_set;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        chlink_pair #(.CW(CW), .C2W(C2W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb_i    (stb_i[p]),
            .pkg_i    (pkg_i[p]),
            .req_i    (req_i[p]),
            .cnt_i    (cnt_i[p]),
            .cnt2_i   (cnt2_i[p]),
            .link_i   (link_i[p]),
            .hw_set_o (hw_set[p]),
            .toggle_o (toggle_o[p]),
            .std_o    (std_irq_o[2*p +: 2])
        );
    end

    chlink_regs #(.NPAIR(NPAIR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wdata_i  (wdata_i),
        .hw_set_i (hw_set),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );

    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata_o == '0 && !irq_o && toggle_o == '0) || rst_n);
endmodule

// File: tb/chlink_irq_subnode_test.sv
module chlink_irq_subnode_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0] stb = '0, pkg = '0, req = '0;
    logic [3:0][1:0][7:0] cnt = '0;
    logic [3:0][1:0][3:0] cnt2 = '0;
    logic [3:0][1:0] link = '0;
    logic [3:0] toggle;
    logic [7:0] std_irq;
    logic irq;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R2";

    int st[4], pc[4], pc2[4], pv[4], m_ie[4], m_ir[4];
    int m_std[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    chlink_irq_subnode uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
        .stb_i(stb), .pkg_i(pkg), .req_i(req), .cnt_i(cnt), .cnt2_i(cnt2),
        .link_i(link), .toggle_o(toggle), .std_irq_o(std_irq), .irq_o(irq)
    );

    task automatic model_reset();
        for (int p = 0; p < 4; p++) begin
            st[p] = 0; pc[p] = 0; pc2[p] = 0; pv[p] = 0; m_ie[p] = 0; m_ir[p] = 0;
        end
        for (int i = 0; i < 8; i++) m_std[i] = 0;
    endtask

    task automatic model_edge();
        int act, c, c2, cl, anyl, done, hw;
        if (!rst_n) begin model_reset(); return; end
        for (int i = 0; i < 8; i++) m_std[i] = 0;
        for (int p = 0; p < 4; p++) begin
            act  = (st[p] == 2) ? 1 : 0;
            c    = cnt[p][act];
            c2   = cnt2[p][act];
            cl   = link[p][act];
            anyl = (link[p] != 0) ? 1 : 0;
            done = 0; hw = 0;
            if (stb[p]) begin
                if (pv[p] != 0 && (pkg[p] ? (pc2[p] == 1 && c2 == 0) : (pc[p] == 1 && c == 0)))
                    done = 1;
                if (done != 0) begin
                    hw = cl;
                    if (anyl == 0) st[p] = 0;
                    else st[p] = (st[p] == 2) ? 1 : 2;
                    pv[p] = 0;
                end else begin
                    if (st[p] == 0 && cl != 0) st[p] = 1;
                    pc[p] = c; pc2[p] = c2; pv[p] = 1;
                end
            end
            if (req[p] && c == 0 && cl == 0) m_std[2*p+act] = 1;
            if (wr_en) m_ie[p] = wdata[4*p];
            if (hw != 0) m_ir[p] = 1;
            else if (wr_en) m_ir[p] = wdata[4*p+1];
        end
    endtask

    task automatic check(input logic ok, input string tag, input int act_v, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic compare();
        logic [15:0] e_rd;
        logic [3:0]  e_tg;
        logic [7:0]  e_std;
        logic        e_irq;
        e_rd = '0; e_tg = '0; e_std = '0; e_irq = 1'b0;
        for (int p = 0; p < 4; p++) begin
            e_rd[4*p]   = m_ie[p][0];
            e_rd[4*p+1] = m_ir[p][0];
            e_tg[p]     = (st[p] == 2);
            if (m_ie[p] != 0 && m_ir[p] != 0) e_irq = 1'b1;
        end
        for (int i = 0; i < 8; i++) e_std[i] = m_std[i][0];
        check(rdata == e_rd,     {cur_req, " rdata"},   rdata,   e_rd);
        check(irq == e_irq,      {cur_req, " irq"},     irq,     e_irq);
        check(toggle == e_tg,    {cur_req, " toggle"},  toggle,  e_tg);
        check(std_irq == e_std,  {cur_req, " std_irq"}, std_irq, e_std);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic write_reg(input logic [15:0] d);
        wr_en = 1'b1; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int p, input int ch, input int c);
        cnt[p][ch] = 8'(c); stb[p] = 1'b1;
        tick();
        stb[p] = 1'b0;
    endtask

    task automatic strobe2(input int p, input int ch, input int c, input int c2);
        cnt[p][ch] = 8'(c); cnt2[p][ch] = 4'(c2); stb[p] = 1'b1;
        tick();
        stb[p] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2 reset state
        check(rdata == 16'h0000 && !irq && toggle == 4'h0, "R2 reset", rdata, 0);

        // R1 layout and reserved bits
        cur_req = "R1";
        write_reg(16'hFFFF);
        check(rdata == 16'h3333, "R1 layout", rdata, 16'h3333);
        cur_req = "R10";
        write_reg(16'h0001);
        check(rdata == 16'h0001, "R10 clear by write", rdata, 16'h0001);

        // R3 single mode, pair 0 channel A linked
        cur_req = "R3";
        link[0] = 2'b01;
        strobe(0, 0, 2);
        strobe(0, 0, 1);
        strobe(0, 0, 0);
        check(rdata == 16'h0003, "R3 request set", rdata, 16'h0003);
        check(irq == 1'b1, "R6 combined irq", irq, 1);
        check(toggle[0] == 1'b1, "R8 toggle to B", toggle[0], 1);

        // R5 completion on B with its link clear
        cur_req = "R5";
        write_reg(16'h0001);
        strobe(0, 1, 1);
        strobe(0, 1, 0);
        check(rdata == 16'h0001, "R5 no request", rdata, 16'h0001);
        check(toggle[0] == 1'b0, "R8 toggle back to A", toggle[0], 0);

        // R9 unlink from channel B
        cur_req = "R9";
        strobe(0, 0, 1);
        strobe(0, 0, 0);
        check(toggle[0] == 1'b1, "R9 setup on B", toggle[0], 1);
        link[0] = 2'b00;
        strobe(0, 1, 1);
        strobe(0, 1, 0);
        check(toggle[0] == 1'b0, "R9 toggle cleared", toggle[0], 0);
        write_reg(16'h0000);

        // R4 package mode, pair index 1
        cur_req = "R4";
        pkg[1] = 1'b1; link[1] = 2'b01;
        strobe2(1, 0, 1, 3);
        strobe2(1, 0, 0, 3);
        check(rdata[5] == 1'b0, "R4 primary ignored", rdata[5], 0);
        strobe2(1, 0, 0, 1);
        strobe2(1, 0, 0, 0);
        check(rdata[5] == 1'b1, "R4 secondary drop", rdata[5], 1);

        // R7 standard interrupt, pair index 2
        cur_req = "R7";
        cnt[2][0] = 8'd0; link[2] = 2'b00; req[2] = 1'b1;
        tick();
        req[2] = 1'b0;
        check(std_irq == 8'h10, "R7 std pulse", std_irq, 8'h10);
        check(rdata[9] == 1'b0, "R7 no request", rdata[9], 0);
        tick();
        check(std_irq == 8'h00, "R7 single pulse", std_irq, 0);

        // R11 no strobe no effect, pair index 3
        cur_req = "R11";
        link[3] = 2'b01;
        strobe(3, 0, 1);
        cnt[3][0] = 8'd0;
        repeat (3) tick();
        check(rdata[13] == 1'b0, "R11 ignored without strobe", rdata[13], 0);
        strobe(3, 0, 0);
        check(rdata[13] == 1'b1, "R11 strobed drop", rdata[13], 1);

        // R10 collision: hw set and clearing write together
        cur_req = "R10";
        link[0] = 2'b01;
        strobe(0, 0, 1);
        cnt[0][0] = 8'd0; stb[0] = 1'b1; wr_en = 1'b1; wdata = 16'h0000;
        tick();
        stb[0] = 1'b0; wr_en = 1'b0;
        check(rdata == 16'h0002, "R10 hw set wins", rdata, 16'h0002);
        check(irq == 1'b0, "R6 masked", irq, 0);

        repeat (2) tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule